// File: doc/BRIEF.md
# Daisy-Chained Serial Slave Readout Port

This block hands the latest 18-bit conversion result to a host over a clocked serial line. The host controls the serial clock and the active-low select. While the select is asserted, every clock transition of the chosen polarity moves one bit of the stored word onto the data output, starting with the most significant bit. The converter side tells the port that a new result is ready by dropping its busy signal. At that moment the result is captured, either unchanged or with the top bit flipped to give twos-complement coding.

Several converters can share one output line. The data input of this port is shifted into the low end of its register as local bits leave the top. After the local word, the port therefore repeats on its output what an upstream port drove into it, delayed by exactly one word. If the host has begun a read but has not finished it when the next result arrives, the unread word is dropped, the new one is loaded, and a one-cycle error pulse is raised.

The serial clock, select and data input are asynchronous to the system clock. Each passes through a two-stage synchronizer, and transitions of the serial clock are found by comparing successive synchronized samples. Each half period of the serial clock must span at least four system clocks.

Top module: `daisy_serial_port`

## Requirements
- R1: During reset and right after it, `sdo_o` and `rd_err_o` are 0.
- R2: A high-to-low transition of `busy_i` captures `result_i`. If `bin_code_i` is 1, the word is stored as is. If it is 0, bit 17 is inverted, so an all-zero result reads back as 0x20000.
- R3: When the select is asserted, `sdo_o` shows bit 17 before any clock transition. Update transitions 1 to 18 then place bits 17 down to 0 on `sdo_o`, one bit per transition.
- R4: With `sclk_inv_i` = 0, the update transition is the rising edge and the sample transition is the falling edge, and the clock idles low. With `sclk_inv_i` = 1 the two are swapped and the clock idles high.
- R5: While `cs_n_i` is 1, transitions on `sclk_i` do not move the stored word, and `sdo_o` is driven 0.
- R6: At each sample transition the level on `sdi_i` enters bit 0 of the register. The value taken at sample transition k appears on `sdo_o` at update transition k+18.
- R7: `rd_err_o` pulses high for exactly one system clock when a new result is captured while the current word has had between 1 and 17 sample transitions. It stays low if the word had 0 or 18 or more.
- R8: Capturing a result clears the sample counter and reloads the register, so the next read returns the new word starting at bit 17.
- R9: A read that is cut short by releasing the select keeps its partial count. A new result that arrives after that is reported as an incomplete read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Conversion busy flag; its falling edge delivers a new result |
| result_i | input | WIDTH | Conversion result, valid at the falling edge of busy_i |
| bin_code_i | input | 1 | 1 = straight binary, 0 = twos complement (MSB inverted) |
| sclk_i | input | 1 | External serial clock from the host |
| cs_n_i | input | 1 | Active-low select that gates the serial clock |
| sdi_i | input | 1 | Chained data from an upstream port |
| sclk_inv_i | input | 1 | Selects the update edge: 0 = rising, 1 = falling |
| sdo_o | output | 1 | Serial data output |
| rd_err_o | output | 1 | One-clock pulse flagging an incomplete read |

## Verification
A stored word that is corrupted, coded wrongly or shifted by one position appears as a mismatch in the first 18 bits of the next read, within a few microseconds of the select being asserted. Wrong chain alignment changes only bits 19 to 36 of a long read, so each read runs for twice the word length. A sample counter that is wrong is visible only when the next busy falling edge arrives: `rd_err_o` either pulses when it should not or stays silent, one system clock after that edge. The bench therefore places busy edges after reads of 0, 5, 10 and 18 or more transitions.

// File: rtl/dsport_pkg.sv
package dsport_pkg;

  localparam int WORD_W      = 18;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    UPD_ON_RISE = 1'b0,
    UPD_ON_FALL = 1'b1
  } edge_sel_e;

endpackage

// File: rtl/dsport_sync.sv
module dsport_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_one
      logic r;
      always_ff @(posedge clk) begin
        if (rst) r <= RST_VAL;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_many
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dsport_edge.sv
module dsport_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);

  logic prev;

  dsport_sync #(.STAGES(STAGES), .RST_VAL(RST_VAL)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin),
    .q   (lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

endmodule

// File: rtl/dsport_track.sv
module dsport_track #(
  parameter int W = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic smp,
  output logic rd_err
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [CW-1:0] cnt;
  logic          partial;

  assign partial = (cnt != '0) && (cnt != FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      rd_err <= 1'b0;
    end else begin
      rd_err <= load && partial;
      if (load)
        cnt <= '0;
      else if (smp && cnt != FULL)
        cnt <= cnt + 1'b1;
    end
  end

  // R7: the error flag lasts a single cycle
  p_err_single_r7: assert property (@(posedge clk) disable iff (rst)
    rd_err |=> !rd_err);

  // R7: an error only follows a capture of new data
  p_err_after_load_r7: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> $past(load));

  // R8: capture empties the counter
  p_cnt_clear_r8: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == '0));

  // R9: the count saturates at one word
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);

endmodule

// File: rtl/dsport_shifter.sv
module dsport_shifter #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         cs_act,
  input  logic         cs_start,
  input  logic         upd,
  input  logic         smp,
  input  logic         sdi,
  output logic         sdo
);

  logic [W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
    end else if (load) begin
      sreg <= load_word;
    end else if (smp) begin
      sreg <= {sreg[W-2:0], sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      sdo <= 1'b0;
    else if (!cs_act)
      sdo <= 1'b0;
    else if (cs_start || upd)
      sdo <= sreg[W-1];
  end

  // R5: with the select released and no capture, the word does not move
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!cs_act && !load) |=> $stable(sreg));

endmodule

// File: rtl/daisy_serial_port.sv
module daisy_serial_port #(
  parameter int WIDTH       = dsport_pkg::WORD_W,
  parameter int SYNC_STAGES = dsport_pkg::SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_i,
  input  logic [WIDTH-1:0] result_i,
  input  logic             bin_code_i,
  input  logic             sclk_i,
  input  logic             cs_n_i,
  input  logic             sdi_i,
  input  logic             sclk_inv_i,
  output logic             sdo_o,
  output logic             rd_err_o
);

  import dsport_pkg::*;

  logic sclk_lvl, sclk_rise, sclk_fall;
  logic cs_n_lvl, cs_n_prev, cs_act, cs_start;
  logic sdi_s;
  logic busy_q, load;
  logic upd, smp;
  logic [WIDTH-1:0] load_word;
  edge_sel_e sel;

  dsport_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk (
    .clk  (clk),
    .rst  (rst),
    .pin  (sclk_i),
    .lvl  (sclk_lvl),
    .rise (sclk_rise),
    .fall (sclk_fall)
  );

  dsport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs (
    .clk (clk),
    .rst (rst),
    .d   (cs_n_i),
    .q   (cs_n_lvl)
  );

  dsport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi (
    .clk (clk),
    .rst (rst),
    .d   (sdi_i),
    .q   (sdi_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_prev <= 1'b1;
      busy_q    <= 1'b0;
    end else begin
      cs_n_prev <= cs_n_lvl;
      busy_q    <= busy_i;
    end
  end

  assign cs_act   = ~cs_n_lvl;
  assign cs_start = cs_act & cs_n_prev;
  assign load     = busy_q & ~busy_i;

  assign load_word = bin_code_i ? result_i
                                : {~result_i[WIDTH-1], result_i[WIDTH-2:0]};

  assign sel = edge_sel_e'(sclk_inv_i);
  assign upd = cs_act & ((sel == UPD_ON_RISE) ? sclk_rise : sclk_fall);
  assign smp = cs_act & ((sel == UPD_ON_RISE) ? sclk_fall : sclk_rise);

  dsport_shifter #(.W(WIDTH)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_word (load_word),
    .cs_act    (cs_act),
    .cs_start  (cs_start),
    .upd       (upd),
    .smp       (smp),
    .sdi       (sdi_s),
    .sdo       (sdo_o)
  );

  dsport_track #(.W(WIDTH)) u_track (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .smp    (smp),
    .rd_err (rd_err_o)
  );

  // R5: the output line is quiet one cycle after the select is seen released
  p_sdo_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !sdo_o);

  // R4: update and sample transitions never coincide
  p_edges_apart_r4: assert property (@(posedge clk) disable iff (rst)
    !(upd && smp));

  // R1: nothing reaches the outputs while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!sdo_o && !rd_err_o));

endmodule

// File: tb/daisy_serial_port_test.sv
module daisy_serial_port_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = dsport_pkg::WORD_W;
  localparam int H = 6;

  logic clk, rst, busy, bin, sclk, cs_n, sdi, inv;
  logic [W-1:0] result;
  logic sdo, rd_err;

  int vecs = 0;
  int bad = 0;
  int err_pulses = 0;
  bit err_wide = 0;
  bit err_prev = 0;
  bit finished = 0;

  daisy_serial_port uut (
    .clk        (clk),
    .rst        (rst),
    .busy_i     (busy),
    .result_i   (result),
    .bin_code_i (bin),
    .sclk_i     (sclk),
    .cs_n_i     (cs_n),
    .sdi_i      (sdi),
    .sclk_inv_i (inv),
    .sdo_o      (sdo),
    .rd_err_o   (rd_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rst) begin
      err_prev = 0;
    end else begin
      if (rd_err) err_pulses++;
      if (rd_err && err_prev) err_wide = 1;
      err_prev = rd_err;
    end
  end

  function automatic logic [W-1:0] coded(input logic [W-1:0] r, input logic b);
    return b ? r : (r ^ (1 << (W-1)));
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse_busy(input logic [W-1:0] w, input logic b);
    result = w;
    bin = b;
    busy = 1'b1;
    repeat (3) @(negedge clk);
    busy = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(input int n, input logic [W-1:0] up,
                         output logic pre, output logic [2*W-1:0] got);
    got = '0;
    sclk = inv;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    pre = sdo;
    for (int k = 0; k < n; k++) begin
      sclk = ~inv;
      sdi = (k < W) ? up[W-1-k] : 1'b0;
      repeat (H) @(negedge clk);
      got = {got[2*W-2:0], sdo};
      sclk = inv;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic end_read();
    cs_n = 1'b1;
    sdi = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic set_inv(input logic v);
    inv = v;
    sclk = v;
    repeat (H) @(negedge clk);
  endtask

  task automatic full_check(input logic [W-1:0] r, input logic b,
                            input logic [W-1:0] up, input string tag);
    logic pre;
    logic [2*W-1:0] got;
    do_read(2*W, up, pre, got);
    check(pre == coded(r, b)[W-1], {tag, " R3 msb before first edge"},
          64'(pre), 64'(coded(r, b)[W-1]));
    check(got[2*W-1:W] == coded(r, b), {tag, " R3 local word"},
          64'(got[2*W-1:W]), 64'(coded(r, b)));
    check(got[W-1:0] == up, {tag, " R6 chained word"},
          64'(got[W-1:0]), 64'(up));
    end_read();
    check(sdo == 1'b0, {tag, " R5 sdo low when deselected"}, 64'(sdo), 64'd0);
  endtask

  initial begin
    int e0;
    logic pre;
    logic [2*W-1:0] got;
    void'($urandom(32'd4242));
    rst = 1'b1; busy = 1'b0; bin = 1'b1; sclk = 1'b0; cs_n = 1'b1;
    sdi = 1'b0; inv = 1'b0; result = '0;
    repeat (5) @(negedge clk);
    check(sdo == 1'b0, "R1 sdo in reset", 64'(sdo), 64'd0);
    check(rd_err == 1'b0, "R1 rd_err in reset", 64'(rd_err), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(sdo == 1'b0 && rd_err == 1'b0, "R1 outputs after reset",
          64'({sdo, rd_err}), 64'd0);

    // R2 R3 R4 R6: rising-edge update, straight binary
    set_inv(1'b0);
    pulse_busy(18'h2D5A3, 1'b1);
    full_check(18'h2D5A3, 1'b1, 18'h15A5C, "dir_rise");

    // R2 R4: falling-edge update, twos complement of zero gives 0x20000
    set_inv(1'b1);
    pulse_busy(18'h00000, 1'b0);
    full_check(18'h00000, 1'b0, 18'h3FFFF, "dir_fall_r2");

    // R5: clock toggles while deselected are ignored
    set_inv(1'b0);
    pulse_busy(18'h1C3E7, 1'b1);
    for (int i = 0; i < 7; i++) begin
      sclk = 1'b1; repeat (H) @(negedge clk);
      sclk = 1'b0; repeat (H) @(negedge clk);
    end
    check(sdo == 1'b0, "R5 sdo quiet during ignored clocks", 64'(sdo), 64'd0);
    full_check(18'h1C3E7, 1'b1, 18'h00F0F, "ignore_r5");

    // R7 R8: new result during a partial read with select held
    pulse_busy(18'h0ABCD, 1'b1);
    do_read(10, 18'h0, pre, got);
    e0 = err_pulses;
    pulse_busy(18'h3A5C1, 1'b0);
    check(err_pulses == e0 + 1, "R7 error on partial read",
          64'(err_pulses - e0), 64'd1);
    end_read();
    full_check(18'h3A5C1, 1'b0, 18'h2AAAA, "reload_r8");

    // R7: completed read followed by new data gives no error
    e0 = err_pulses;
    pulse_busy(18'h12345, 1'b1);
    check(err_pulses == e0, "R7 no error after complete read",
          64'(err_pulses - e0), 64'd0);

    // R9: interrupted read counts as incomplete
    do_read(5, 18'h0, pre, got);
    end_read();
    e0 = err_pulses;
    pulse_busy(18'h2F00F, 1'b1);
    check(err_pulses == e0 + 1, "R9 interrupted read flagged",
          64'(err_pulses - e0), 64'd1);

    // R7: no read at all gives no error
    e0 = err_pulses;
    pulse_busy(18'h04444, 1'b1);
    check(err_pulses == e0, "R7 no error without a read",
          64'(err_pulses - e0), 64'd0);
    full_check(18'h04444, 1'b1, 18'h13579, "after_idle_r8");

    // random mix of words, coding, edge choice and chained data
    e0 = err_pulses;
    for (int it = 0; it < 24; it++) begin
      logic [W-1:0] r, up;
      logic b, v;
      r  = W'($urandom);
      up = W'($urandom);
      b  = 1'($urandom);
      v  = 1'($urandom);
      set_inv(v);
      pulse_busy(r, b);
      full_check(r, b, up, "rand_r2_r4");
    end
    check(err_pulses == e0, "R7 no error on random complete reads",
          64'(err_pulses - e0), 64'd0);
    check(err_wide == 1'b0, "R7 error pulse one clock wide",
          64'(err_wide), 64'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vecs++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

endmodule